// File: doc/BRIEF.md
# PHY management register file

This block holds the management register set of a Fast Ethernet transceiver as a MAC sees it through its management window. Software first loads a 16-bit target word that names a PHY address and a register index. A data strobe then writes into the selected register, and a combinational read port always returns the selected register. Bit-level serial management framing, analog link detection and real auto-negotiation signalling are not part of the block. Register access is parallel.

The set holds a control word, a status word, two identifier words, a local advertisement word and a link-partner word. Status capability bits and both identifiers are constants. The link bits in status and the whole partner word follow a `link_ok` input, one clock late. Setting the top control bit starts a self-clearing soft reset, which reloads every register. A target word that names a different PHY reads as all ones and cannot write anything.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After hardware reset the target word is 0x0000. With `PHY_ADDR` = 0, the reset contents read as follows: control 0x3100 (speed bit 13, auto-negotiation enable bit 12, full duplex bit 8); status 0x7848 (100 full/half bits 14/13, 10 full/half bits 12/11, preamble suppression bit 6, auto-negotiation ability bit 3); advertisement 0x01E1 (bits 8,7,6,5 and selector bit 0); partner 0x0080.
- R2: The clock after `link_ok` is sampled high, status reads 0x786C (link bit 2 and negotiation-done bit 5 added) and partner reads 0x01E1. The clock after it is sampled low, status reads 0x7848 and partner reads 0x0080. Control and advertisement do not change.
- R3: A data write to index 0 with bit 15 clear stores all 16 bits into control.
- R4: A data write to index 4 stores all 16 bits into advertisement.
- R5: A data write to index 0 with bit 15 set is not stored. Instead it reloads control to 0x3100 and advertisement to 0x01E1. Status and partner then follow the `link_ok` value sampled at that same edge.
- R6: Data writes to index 1 (status), 2 and 3 (identifiers), 5 (partner) and 6 (expansion) change no register.
- R7: Index 2 reads the `ID_HI` parameter and index 3 reads the `ID_LO` parameter.
- R8: Index 6, the vendor indices 16 to 20 and every other undefined index all read 0x0000.
- R9: When target bits 15:8 differ from `PHY_ADDR`, the read port returns 0xFFFF and a data write has no effect.
- R10: The target word carries the PHY address in bits 15:8 and the register index in bits 7:0. A data write in the same cycle as a target load uses the target value held before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_ok | input | 1 | Current link state from the line side |
| tgt_wr | input | 1 | Load the target word |
| tgt_wdata | input | 16 | Target word: PHY address [15:8], register index [7:0] |
| dat_wr | input | 1 | Write strobe for the selected register |
| dat_wdata | input | 16 | Write data |
| dat_rdata | output | 16 | Contents of the selected register |

## Verification
Two operations can land on the same edge: a soft-reset write to control, and a change of `link_ok`. The reload must take its link bits from the new link value and not from a stale one. The bench raises `link_ok` in the very cycle of the reset write, then reads status and partner and compares them with the link-up values. A second coincidence is a target load issued together with a data write. The bench checks that the data landed under the old index and that the newly selected register is untouched. Randomly mixed strobes and link toggles then repeat both cases many times against a bench model.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

   localparam int unsigned REG_W   = 16;
   localparam int unsigned FIELD_W = 8;

   typedef logic [REG_W-1:0]   mreg_t;
   typedef logic [FIELD_W-1:0] field_t;

   typedef struct packed {
      field_t phy;
      field_t idx;
   } tgt_t;

   localparam field_t IDX_CTRL    = 8'd0;
   localparam field_t IDX_STAT    = 8'd1;
   localparam field_t IDX_ID_HI   = 8'd2;
   localparam field_t IDX_ID_LO   = 8'd3;
   localparam field_t IDX_ADV     = 8'd4;
   localparam field_t IDX_PARTNER = 8'd5;

   localparam int unsigned CTRL_RST_BIT  = 15;
   localparam int unsigned CTRL_SPD_BIT  = 13;
   localparam int unsigned CTRL_ANEN_BIT = 12;
   localparam int unsigned CTRL_FDX_BIT  = 8;

   localparam int unsigned ST_100F_BIT  = 14;
   localparam int unsigned ST_100H_BIT  = 13;
   localparam int unsigned ST_10F_BIT   = 12;
   localparam int unsigned ST_10H_BIT   = 11;
   localparam int unsigned ST_PRE_BIT   = 6;
   localparam int unsigned ST_ANDONE_BIT = 5;
   localparam int unsigned ST_ANABL_BIT = 3;
   localparam int unsigned ST_LINK_BIT  = 2;

   localparam int unsigned ADV_100F_BIT = 8;
   localparam int unsigned ADV_100_BIT  = 7;
   localparam int unsigned ADV_10F_BIT  = 6;
   localparam int unsigned ADV_10_BIT   = 5;
   localparam int unsigned ADV_SEL_BIT  = 0;

   function automatic mreg_t bitv(input int unsigned pos);
      return mreg_t'(1) << pos;
   endfunction

   localparam mreg_t CTRL_INIT = bitv(CTRL_SPD_BIT) | bitv(CTRL_ANEN_BIT) | bitv(CTRL_FDX_BIT);
   localparam mreg_t STAT_CAPS = bitv(ST_100F_BIT) | bitv(ST_100H_BIT) | bitv(ST_10F_BIT)
                               | bitv(ST_10H_BIT) | bitv(ST_PRE_BIT) | bitv(ST_ANABL_BIT);
   localparam mreg_t STAT_UP   = bitv(ST_LINK_BIT) | bitv(ST_ANDONE_BIT);
   localparam mreg_t ADV_INIT  = bitv(ADV_100F_BIT) | bitv(ADV_100_BIT) | bitv(ADV_10F_BIT)
                               | bitv(ADV_10_BIT) | bitv(ADV_SEL_BIT);
   localparam mreg_t PART_DOWN = bitv(ADV_100_BIT);
   localparam mreg_t PART_UP   = PART_DOWN | bitv(ADV_100F_BIT) | bitv(ADV_10F_BIT)
                               | bitv(ADV_10_BIT) | bitv(ADV_SEL_BIT);

endpackage

// File: rtl/phy_mgmt_target.sv
module phy_mgmt_target
   import phy_mgmt_pkg::*;
#(
   parameter field_t PHY_ADDR = '0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  tgt_t load_val,
   output tgt_t tgt_q,
   output logic hit
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_q <= '0;
      end else if (load) begin
         tgt_q <= load_val;
      end
   end

   assign hit = (tgt_q.phy == PHY_ADDR);

endmodule

// File: rtl/phy_mgmt_wregs.sv
module phy_mgmt_wregs
   import phy_mgmt_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   wr,
   input  field_t idx,
   input  mreg_t  wdata,
   output mreg_t  ctrl_q,
   output mreg_t  adv_q
);

   logic soft_rst;

   assign soft_rst = wr && (idx == IDX_CTRL) && wdata[CTRL_RST_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_INIT;
         adv_q  <= ADV_INIT;
      end else if (soft_rst) begin
         ctrl_q <= CTRL_INIT;
         adv_q  <= ADV_INIT;
      end else if (wr) begin
         case (idx)
            IDX_CTRL: ctrl_q <= wdata;
            IDX_ADV:  adv_q  <= wdata;
            default:  ;
         endcase
      end
   end

endmodule

// File: rtl/phy_mgmt_linkstat.sv
module phy_mgmt_linkstat
   import phy_mgmt_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  link_ok,
   output mreg_t stat,
   output mreg_t partner
);

   logic link_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         link_q <= 1'b0;
      end else begin
         link_q <= link_ok;
      end
   end

   assign stat    = link_q ? (STAT_CAPS | STAT_UP) : STAT_CAPS;
   assign partner = link_q ? PART_UP : PART_DOWN;

endmodule

// File: rtl/phy_mgmt_rdmux.sv
module phy_mgmt_rdmux
   import phy_mgmt_pkg::*;
#(
   parameter mreg_t ID_HI = 16'h1C5A,
   parameter mreg_t ID_LO = 16'hB3E1
) (
   input  logic   hit,
   input  field_t idx,
   input  mreg_t  ctrl,
   input  mreg_t  stat,
   input  mreg_t  adv,
   input  mreg_t  partner,
   output mreg_t  rdata
);

   mreg_t sel;

   always_comb begin
      case (idx)
         IDX_CTRL:    sel = ctrl;
         IDX_STAT:    sel = stat;
         IDX_ID_HI:   sel = ID_HI;
         IDX_ID_LO:   sel = ID_LO;
         IDX_ADV:     sel = adv;
         IDX_PARTNER: sel = partner;
         default:     sel = '0;
      endcase
   end

   assign rdata = hit ? sel : '1;

endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
   import phy_mgmt_pkg::*;
#(
   parameter logic [7:0]  PHY_ADDR = 8'h00,
   parameter logic [15:0] ID_HI    = 16'h1C5A,
   parameter logic [15:0] ID_LO    = 16'hB3E1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        link_ok,
   input  logic        tgt_wr,
   input  logic [15:0] tgt_wdata,
   input  logic        dat_wr,
   input  logic [15:0] dat_wdata,
   output logic [15:0] dat_rdata
);

   generate
      if (2 * FIELD_W != REG_W) begin : g_bad_layout
         $error("target word must hold exactly two fields");
      end
   endgenerate

   tgt_t  tgt_q;
   logic  hit;
   mreg_t ctrl_q;
   mreg_t adv_q;
   mreg_t stat;
   mreg_t partner;

   phy_mgmt_target #(.PHY_ADDR(PHY_ADDR)) u_target (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tgt_wr),
      .load_val (tgt_t'(tgt_wdata)),
      .tgt_q    (tgt_q),
      .hit      (hit)
   );

   phy_mgmt_wregs u_wregs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (dat_wr && hit),
      .idx    (tgt_q.idx),
      .wdata  (dat_wdata),
      .ctrl_q (ctrl_q),
      .adv_q  (adv_q)
   );

   phy_mgmt_linkstat u_link (
      .clk     (clk),
      .rst_n   (rst_n),
      .link_ok (link_ok),
      .stat    (stat),
      .partner (partner)
   );

   phy_mgmt_rdmux #(.ID_HI(ID_HI), .ID_LO(ID_LO)) u_rdmux (
      .hit     (hit),
      .idx     (tgt_q.idx),
      .ctrl    (ctrl_q),
      .stat    (stat),
      .adv     (adv_q),
      .partner (partner),
      .rdata   (dat_rdata)
   );

endmodule

// File: rtl/phy_mgmt_regfile_chk.sv
module phy_mgmt_regfile_chk #(
   parameter logic [7:0]  PHY_ADDR = 8'h00,
   parameter logic [15:0] ID_HI    = 16'h1C5A,
   parameter logic [15:0] ID_LO    = 16'hB3E1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        link_ok,
   input logic        dat_wr,
   input logic [15:0] dat_wdata,
   input logic [15:0] dat_rdata,
   input logic [15:0] tgt_q,
   input logic [15:0] ctrl_q,
   input logic [15:0] adv_q
);

   logic       armed;
   logic       hit_c;
   logic [7:0] idx_c;

   assign hit_c = (tgt_q[15:8] == PHY_ADDR);
   assign idx_c = tgt_q[7:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assert_ctrl_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && hit_c && idx_c == 8'd0 && !dat_wdata[15]) |=> (ctrl_q == $past(dat_wdata)));

   assert_adv_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && hit_c && idx_c == 8'd4) |=> (adv_q == $past(dat_wdata)));

   assert_soft_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && hit_c && idx_c == 8'd0 && dat_wdata[15]) |=> (ctrl_q == 16'h3100 && adv_q == 16'h01E1));

   assert_ro_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && (idx_c inside {8'd1, 8'd2, 8'd3, 8'd5, 8'd6})) |=> ($stable(ctrl_q) && $stable(adv_q)));

   assert_id_words_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_c && idx_c == 8'd2) |-> (dat_rdata == ID_HI));

   assert_foreign_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_c |-> (dat_rdata == 16'hFFFF));

   assert_foreign_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && !hit_c) |=> ($stable(ctrl_q) && $stable(adv_q)));

   assert_link_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && hit_c && idx_c == 8'd1) |-> (dat_rdata[2] == $past(link_ok) && dat_rdata[5] == $past(link_ok)));

endmodule

bind phy_mgmt_regfile phy_mgmt_regfile_chk #(
   .PHY_ADDR (PHY_ADDR),
   .ID_HI    (ID_HI),
   .ID_LO    (ID_LO)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .link_ok   (link_ok),
   .dat_wr    (dat_wr),
   .dat_wdata (dat_wdata),
   .dat_rdata (dat_rdata),
   .tgt_q     (tgt_q),
   .ctrl_q    (ctrl_q),
   .adv_q     (adv_q)
);

// File: tb/test_phy_mgmt_regfile.sv
`timescale 1ns/1ps
module test_phy_mgmt_regfile;

   localparam logic [7:0]  PHY   = 8'h00;
   localparam logic [15:0] IDH   = 16'h1C5A;
   localparam logic [15:0] IDL   = 16'hB3E1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        link_ok = 1'b0;
   logic        tgt_wr = 1'b0;
   logic [15:0] tgt_wdata = '0;
   logic        dat_wr = 1'b0;
   logic [15:0] dat_wdata = '0;
   logic [15:0] dat_rdata;

   int ncheck = 0;
   int nfail  = 0;
   bit done   = 1'b0;

   logic [15:0] m_ctrl = 16'h3100;
   logic [15:0] m_adv  = 16'h01E1;
   logic [15:0] m_tgt  = 16'h0000;
   logic        m_link = 1'b0;

   always #10 clk = ~clk;

   phy_mgmt_regfile #(.PHY_ADDR(PHY), .ID_HI(IDH), .ID_LO(IDL)) i_phy_mgmt_regfile (
      .clk       (clk),
      .rst_n     (rst_n),
      .link_ok   (link_ok),
      .tgt_wr    (tgt_wr),
      .tgt_wdata (tgt_wdata),
      .dat_wr    (dat_wr),
      .dat_wdata (dat_wdata),
      .dat_rdata (dat_rdata)
   );

   function automatic logic [15:0] exp_read();
      if (m_tgt[15:8] != PHY) return 16'hFFFF;
      case (m_tgt[7:0])
         8'd0: return m_ctrl;
         8'd1: return m_link ? 16'h786C : 16'h7848;
         8'd2: return IDH;
         8'd3: return IDL;
         8'd4: return m_adv;
         8'd5: return m_link ? 16'h01E1 : 16'h0080;
         default: return 16'h0000;
      endcase
   endfunction

   function automatic string tag_of();
      if (m_tgt[15:8] != PHY) return "R9";
      case (m_tgt[7:0])
         8'd0: return "R3";
         8'd1: return "R2";
         8'd2, 8'd3: return "R7";
         8'd4: return "R4";
         8'd5: return "R2";
         default: return "R8";
      endcase
   endfunction

   task automatic tick();
      @(posedge clk);
      if (dat_wr && m_tgt[15:8] == PHY) begin
         if (m_tgt[7:0] == 8'd0) begin
            if (dat_wdata[15]) begin
               m_ctrl = 16'h3100;
               m_adv  = 16'h01E1;
            end else begin
               m_ctrl = dat_wdata;
            end
         end else if (m_tgt[7:0] == 8'd4) begin
            m_adv = dat_wdata;
         end
      end
      if (tgt_wr) m_tgt = tgt_wdata;
      m_link = link_ok;
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [15:0] exp);
      ncheck++;
      if (dat_rdata !== exp) begin
         nfail++;
         $display("FAIL %s: target %h read %h expected %h", tag, m_tgt, dat_rdata, exp);
      end
   endtask

   task automatic set_tgt(input logic [7:0] a, input logic [7:0] i);
      tgt_wr = 1'b1;
      tgt_wdata = {a, i};
      tick();
      tgt_wr = 1'b0;
   endtask

   task automatic wr_dat(input logic [15:0] v);
      dat_wr = 1'b1;
      dat_wdata = v;
      tick();
      dat_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [7:0] i, input string tag);
      set_tgt(a, i);
      chk(tag, exp_read());
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", ncheck - nfail, ncheck);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         ncheck++;
         nfail++;
         $display("FAIL watchdog R1: run hung, got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", 16'h3100);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset contents
      rd(PHY, 8'd1, "R1");
      chk("R1", 16'h7848);
      rd(PHY, 8'd4, "R1");
      chk("R1", 16'h01E1);
      rd(PHY, 8'd5, "R1");
      chk("R1", 16'h0080);

      // R7 identifier words
      rd(PHY, 8'd2, "R7");
      rd(PHY, 8'd3, "R7");

      // R2 link follow, one clock late
      set_tgt(PHY, 8'd1);
      link_ok = 1'b1;
      chk("R2", 16'h7848);
      tick();
      chk("R2", 16'h786C);
      rd(PHY, 8'd5, "R2");
      link_ok = 1'b0;
      tick();
      chk("R2", 16'h0080);
      rd(PHY, 8'd0, "R2");
      rd(PHY, 8'd4, "R2");

      // R3 control store
      set_tgt(PHY, 8'd0);
      wr_dat(16'h0A5A);
      chk("R3", 16'h0A5A);

      // R4 advertisement store
      set_tgt(PHY, 8'd4);
      wr_dat(16'hBEEF);
      chk("R4", 16'hBEEF);

      // R5 soft reset coinciding with link rising
      set_tgt(PHY, 8'd0);
      link_ok = 1'b1;
      wr_dat(16'hC0DE);
      chk("R5", 16'h3100);
      rd(PHY, 8'd4, "R5");
      chk("R5", 16'h01E1);
      rd(PHY, 8'd1, "R5");
      chk("R5", 16'h786C);

      // R6 read-only indices ignore writes
      set_tgt(PHY, 8'd0);
      wr_dat(16'h0123);
      set_tgt(PHY, 8'd4);
      wr_dat(16'h4567);
      foreach (m_tgt[k]) if (k < 5) begin
         logic [7:0] ro;
         ro = (k == 0) ? 8'd1 : (k == 1) ? 8'd2 : (k == 2) ? 8'd3 : (k == 3) ? 8'd5 : 8'd6;
         set_tgt(PHY, ro);
         wr_dat(16'h0000);
         chk("R6", exp_read());
      end
      rd(PHY, 8'd0, "R6");
      chk("R6", 16'h0123);
      rd(PHY, 8'd4, "R6");
      chk("R6", 16'h4567);

      // R8 zero-reading indices
      rd(PHY, 8'd6, "R8");
      for (int v = 16; v <= 20; v++) rd(PHY, 8'(v), "R8");
      rd(PHY, 8'd7, "R8");
      rd(PHY, 8'd200, "R8");
      chk("R8", 16'h0000);

      // R9 foreign address
      rd(PHY + 8'd1, 8'd0, "R9");
      chk("R9", 16'hFFFF);
      wr_dat(16'h1111);
      set_tgt(PHY + 8'd1, 8'd4);
      wr_dat(16'h2222);
      rd(PHY, 8'd4, "R9");
      chk("R9", 16'h4567);
      rd(PHY, 8'd0, "R9");
      chk("R9", 16'h0123);

      // R10 target load and data write in the same cycle
      set_tgt(PHY, 8'd4);
      tgt_wr = 1'b1;
      tgt_wdata = {PHY, 8'd0};
      dat_wr = 1'b1;
      dat_wdata = 16'h3333;
      tick();
      tgt_wr = 1'b0;
      dat_wr = 1'b0;
      chk("R10", 16'h0123);
      rd(PHY, 8'd4, "R10");
      chk("R10", 16'h3333);

      // random mix
      void'($urandom(32'd2024));
      for (int n = 0; n < 600; n++) begin
         logic [31:0] r;
         r = $urandom;
         tgt_wr = r[0];
         tgt_wdata = {(r[3:2] == 2'b00) ? (PHY + 8'd1) : PHY,
                      r[4] ? 8'($urandom % 32) : 8'($urandom % 8)};
         dat_wr = r[5] | r[6];
         dat_wdata = {(r[9:7] == 3'b000), 15'($urandom)};
         if (r[10]) link_ok = ~link_ok;
         tick();
         tgt_wr = 1'b0;
         dat_wr = 1'b0;
         chk(tag_of(), exp_read());
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule